// File: doc/BRIEF.md
# Line-Merging Miss Tracker with Event Counters

This block sits between a first-level data cache and the second-level cache. It tracks every cache line that has an outstanding fetch. When several misses name the same 64-byte line, only the first of them reaches the L2. Each later miss is folded into the live entry as a requester bit. A fill response from the L2 retires the entry and reports, in the same cycle, the full set of requester tags that were waiting on that line.

The single L2 request port also carries store hits that are being written through and prefetch requests. A fixed priority picks one source per cycle. Three saturating event counters record accepted L1 misses, misses squashed by merging, and requests actually handed to the L2. Comparing them shows why the L2 access count can fall below the miss count, because of merging, or rise above it, because of stores and prefetches.

Top module: `mm_fill_tracker`

## Requirements
- R1: Two byte addresses belong to the same line exactly when bits 31..6 are equal. `fill_line` carries bits 31..6 of a line address.
- R2: A miss whose line has no live entry is accepted in the cycle where a free entry exists and `l2_req_ready` is high. In that same cycle `l2_req_valid` is high, `l2_req_kind` is 0 (miss) and `l2_req_addr` equals the miss byte address, and an entry is allocated for the line.
- R3: A miss whose line already has a live entry is accepted with no L2 request. Its tag is added to that entry's mask, and `cnt_squash` rises by one a cycle later.
- R4: Every accepted miss, merged or not, raises `cnt_l1_miss` by one a cycle later.
- R5: `cnt_l2_access` rises by one a cycle after each cycle with `l2_req_valid` and `l2_req_ready` both high, and at no other time.
- R6: A write-through store hit is issued with kind 1 and its byte address. It counts as an L2 access and not as an L1 miss.
- R7: A prefetch to a line with no live entry is issued with kind 2 and counts as an L2 access. A prefetch to a live line is accepted (`pf_ready` high) and dropped, with no request and no count.
- R8: When several sources want the port, a new miss wins over a store, and a store wins over a prefetch. A losing source sees its ready low.
- R9: With all 4 entries live, a miss to a new line is held (`miss_ready` low, no request). A miss that can merge is still accepted.
- R10: A fill that matches a live line raises `done_valid` in the same cycle, with bit t of `done_mask` set for each merged tag t, and frees the entry. A fill for a line that is not live leaves `done_valid` low. A miss in the cycle of its line's fill is handled as a new miss.
- R11: The counters are 32 bits wide and saturate at all ones. After reset all counters read 0 and no entry is live.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | L1 miss request present |
| miss_ready | output | 1 | Miss accepted this cycle |
| miss_addr | input | 32 | Miss byte address |
| miss_tag | input | 3 | Requester tag of the miss |
| st_valid | input | 1 | Write-through store hit present |
| st_ready | output | 1 | Store issued to the L2 this cycle |
| st_addr | input | 32 | Store byte address |
| pf_valid | input | 1 | Prefetch request present |
| pf_ready | output | 1 | Prefetch issued or dropped this cycle |
| pf_addr | input | 32 | Prefetch byte address |
| l2_req_valid | output | 1 | Request offered to the L2 |
| l2_req_ready | input | 1 | L2 takes the request |
| l2_req_addr | output | 32 | Byte address of the request |
| l2_req_kind | output | 2 | 0 miss, 1 store, 2 prefetch |
| fill_valid | input | 1 | Fill response present |
| fill_line | input | 26 | Line address of the fill |
| done_valid | output | 1 | Entry retired this cycle |
| done_mask | output | 8 | Requester tags merged into the retired entry |
| cnt_l1_miss | output | 32 | Accepted L1 misses |
| cnt_squash | output | 32 | Misses merged into a live entry |
| cnt_l2_access | output | 32 | Requests handed to the L2 |

## Verification
Ready signals, the L2 request fields and the completion outputs are combinational in the current inputs and the entry state. They are therefore due in the same cycle as the stimulus, and the bench samples them 2 ns after it drives inputs at the falling edge. Entry changes and counter increments take effect at the next rising edge. The bench reads the counters 1 ns after that edge and compares them with totals it derives from the expected handshakes in its vector table. A second instance with 3-bit counters is driven by the same inputs to reach saturation within the short run.

// File: rtl/mm_pkg.sv
package mm_pkg;
    localparam int DEF_ADDR_W   = 32;
    localparam int DEF_LINE_OFF = 6;
    localparam int DEF_TAG_W    = 3;
    localparam int DEF_ENTRIES  = 4;
    localparam int DEF_CNT_W    = 32;
    localparam int NUM_EVENTS   = 3;

    localparam int EV_L1_MISS = 0;
    localparam int EV_SQUASH  = 1;
    localparam int EV_L2_ACC  = 2;

    typedef enum logic [1:0] {
        REQ_MISS     = 2'd0,
        REQ_WT_STORE = 2'd1,
        REQ_PREFETCH = 2'd2
    } req_kind_e;
endpackage

// File: rtl/mm_entry_table.sv
module mm_entry_table #(
    parameter  int ENTRIES = mm_pkg::DEF_ENTRIES,
    parameter  int LINE_W  = mm_pkg::DEF_ADDR_W - mm_pkg::DEF_LINE_OFF,
    parameter  int TAG_W   = mm_pkg::DEF_TAG_W,
    localparam int NTAGS   = 1 << TAG_W,
    localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LINE_W-1:0] miss_line,
    output logic              miss_hit,
    input  logic [LINE_W-1:0] pf_line,
    output logic              pf_live,
    input  logic              fill_valid,
    input  logic [LINE_W-1:0] fill_line,
    output logic              fill_hit,
    output logic [NTAGS-1:0]  fill_mask,
    output logic              free_any,
    input  logic              alloc_en,
    input  logic              merge_en,
    input  logic [TAG_W-1:0]  req_tag
);
    logic [ENTRIES-1:0]              ent_valid;
    logic [ENTRIES-1:0][LINE_W-1:0]  ent_line;
    logic [ENTRIES-1:0][NTAGS-1:0]   ent_mask;

    logic [ENTRIES-1:0] fill_match, miss_match, pf_match, free_vec;
    logic [IDX_W-1:0]   alloc_idx;
    logic [NTAGS-1:0]   tag_bit;

    assign tag_bit = NTAGS'(1) << req_tag;

    // Per-entry comparators; an entry being retired this cycle no longer counts as live.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign fill_match[g] = fill_valid && ent_valid[g] && (ent_line[g] == fill_line);
        assign miss_match[g] = ent_valid[g] && !fill_match[g] && (ent_line[g] == miss_line);
        assign pf_match[g]   = ent_valid[g] && !fill_match[g] && (ent_line[g] == pf_line);
        assign free_vec[g]   = !ent_valid[g];
    end

    assign miss_hit = |miss_match;
    assign pf_live  = |pf_match;
    assign fill_hit = |fill_match;
    assign free_any = |free_vec;

    always_comb begin
        fill_mask = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (fill_match[i]) fill_mask = fill_mask | ent_mask[i];
        end
    end

    // Lowest free entry is chosen for a new line.
    always_comb begin
        alloc_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (free_vec[i]) alloc_idx = IDX_W'(i);
        end
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                ent_valid[g] <= 1'b0;
                ent_line[g]  <= '0;
                ent_mask[g]  <= '0;
            end else if (fill_match[g]) begin
                ent_valid[g] <= 1'b0;
                ent_mask[g]  <= '0;
            end else if (alloc_en && free_vec[g] && (alloc_idx == IDX_W'(g))) begin
                ent_valid[g] <= 1'b1;
                ent_line[g]  <= miss_line;
                ent_mask[g]  <= tag_bit;
            end else if (merge_en && miss_match[g]) begin
                ent_mask[g]  <= ent_mask[g] | tag_bit;
            end
        end
    end
endmodule

// File: rtl/mm_l2_arbiter.sv
module mm_l2_arbiter
    import mm_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W
) (
    input  logic              miss_want,
    input  logic [ADDR_W-1:0] miss_addr,
    input  logic              st_want,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic              pf_want,
    input  logic [ADDR_W-1:0] pf_addr,
    input  logic              l2_ready,
    output logic              l2_valid,
    output logic [ADDR_W-1:0] l2_addr,
    output req_kind_e         l2_kind,
    output logic              grant_miss,
    output logic              grant_st,
    output logic              grant_pf
);
    logic sel_miss, sel_st, sel_pf;

    assign sel_miss = miss_want;
    assign sel_st   = st_want && !miss_want;
    assign sel_pf   = pf_want && !miss_want && !st_want;

    assign l2_valid   = sel_miss || sel_st || sel_pf;
    assign grant_miss = sel_miss && l2_ready;
    assign grant_st   = sel_st && l2_ready;
    assign grant_pf   = sel_pf && l2_ready;

    always_comb begin
        if (sel_miss) begin
            l2_addr = miss_addr;
            l2_kind = REQ_MISS;
        end else if (sel_st) begin
            l2_addr = st_addr;
            l2_kind = REQ_WT_STORE;
        end else if (sel_pf) begin
            l2_addr = pf_addr;
            l2_kind = REQ_PREFETCH;
        end else begin
            l2_addr = '0;
            l2_kind = REQ_MISS;
        end
    end
endmodule

// File: rtl/mm_event_counters.sv
module mm_event_counters #(
    parameter int CNT_W  = mm_pkg::DEF_CNT_W,
    parameter int EVENTS = mm_pkg::NUM_EVENTS
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [EVENTS-1:0]           inc,
    output logic [EVENTS-1:0][CNT_W-1:0] count
);
    for (genvar g = 0; g < EVENTS; g++) begin : g_cnt
        always_ff @(posedge clk) begin
            if (rst)
                count[g] <= '0;
            else if (inc[g] && (count[g] != {CNT_W{1'b1}}))
                count[g] <= count[g] + CNT_W'(1);
        end
    end
endmodule

// File: rtl/mm_fill_tracker.sv
module mm_fill_tracker
    import mm_pkg::*;
#(
    parameter  int ADDR_W   = DEF_ADDR_W,
    parameter  int LINE_OFF = DEF_LINE_OFF,
    parameter  int TAG_W    = DEF_TAG_W,
    parameter  int ENTRIES  = DEF_ENTRIES,
    parameter  int CNT_W    = DEF_CNT_W,
    localparam int LINE_W   = ADDR_W - LINE_OFF,
    localparam int NTAGS    = 1 << TAG_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              miss_valid,
    output logic              miss_ready,
    input  logic [ADDR_W-1:0] miss_addr,
    input  logic [TAG_W-1:0]  miss_tag,
    input  logic              st_valid,
    output logic              st_ready,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic              pf_valid,
    output logic              pf_ready,
    input  logic [ADDR_W-1:0] pf_addr,
    output logic              l2_req_valid,
    input  logic              l2_req_ready,
    output logic [ADDR_W-1:0] l2_req_addr,
    output logic [1:0]        l2_req_kind,
    input  logic              fill_valid,
    input  logic [LINE_W-1:0] fill_line,
    output logic              done_valid,
    output logic [NTAGS-1:0]  done_mask,
    output logic [CNT_W-1:0]  cnt_l1_miss,
    output logic [CNT_W-1:0]  cnt_squash,
    output logic [CNT_W-1:0]  cnt_l2_access
);
    logic miss_hit, pf_live, free_any;
    logic grant_miss, grant_st, grant_pf;
    logic merge_fire;
    req_kind_e kind;
    logic [NUM_EVENTS-1:0]            ev_inc;
    logic [NUM_EVENTS-1:0][CNT_W-1:0] ev_cnt;

    mm_entry_table #(
        .ENTRIES(ENTRIES), .LINE_W(LINE_W), .TAG_W(TAG_W)
    ) u_table (
        .clk       (clk),
        .rst       (rst),
        .miss_line (miss_addr[ADDR_W-1:LINE_OFF]),
        .miss_hit  (miss_hit),
        .pf_line   (pf_addr[ADDR_W-1:LINE_OFF]),
        .pf_live   (pf_live),
        .fill_valid(fill_valid),
        .fill_line (fill_line),
        .fill_hit  (done_valid),
        .fill_mask (done_mask),
        .free_any  (free_any),
        .alloc_en  (grant_miss),
        .merge_en  (merge_fire),
        .req_tag   (miss_tag)
    );

    mm_l2_arbiter #(.ADDR_W(ADDR_W)) u_arb (
        .miss_want (miss_valid && !miss_hit && free_any),
        .miss_addr (miss_addr),
        .st_want   (st_valid),
        .st_addr   (st_addr),
        .pf_want   (pf_valid && !pf_live),
        .pf_addr   (pf_addr),
        .l2_ready  (l2_req_ready),
        .l2_valid  (l2_req_valid),
        .l2_addr   (l2_req_addr),
        .l2_kind   (kind),
        .grant_miss(grant_miss),
        .grant_st  (grant_st),
        .grant_pf  (grant_pf)
    );

    assign merge_fire  = miss_valid && miss_hit;
    assign miss_ready  = miss_hit || (free_any && l2_req_ready);
    assign st_ready    = grant_st;
    assign pf_ready    = pf_live || grant_pf;
    assign l2_req_kind = kind;

    assign ev_inc[EV_L1_MISS] = merge_fire || grant_miss;
    assign ev_inc[EV_SQUASH]  = merge_fire;
    assign ev_inc[EV_L2_ACC]  = l2_req_valid && l2_req_ready;

    mm_event_counters #(.CNT_W(CNT_W), .EVENTS(NUM_EVENTS)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .inc  (ev_inc),
        .count(ev_cnt)
    );

    assign cnt_l1_miss   = ev_cnt[EV_L1_MISS];
    assign cnt_squash    = ev_cnt[EV_SQUASH];
    assign cnt_l2_access = ev_cnt[EV_L2_ACC];
endmodule

// File: rtl/mm_fill_tracker_chk.sv
module mm_fill_tracker_chk #(
    parameter int ADDR_W = 32,
    parameter int NTAGS  = 8,
    parameter int CNT_W  = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              miss_valid,
    input logic              miss_ready,
    input logic              st_valid,
    input logic              st_ready,
    input logic              pf_valid,
    input logic              pf_ready,
    input logic              l2_req_valid,
    input logic              l2_req_ready,
    input logic [1:0]        l2_req_kind,
    input logic              done_valid,
    input logic [NTAGS-1:0]  done_mask,
    input logic [CNT_W-1:0]  cnt_l1_miss,
    input logic [CNT_W-1:0]  cnt_squash,
    input logic [CNT_W-1:0]  cnt_l2_access
);
    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

    p_l1_count_r4: assert property (@(posedge clk) disable iff (rst)
        (miss_valid && miss_ready && cnt_l1_miss != CMAX)
        |=> cnt_l1_miss == $past(cnt_l1_miss) + CNT_W'(1));

    p_l2_count_r5: assert property (@(posedge clk) disable iff (rst)
        (l2_req_valid && l2_req_ready && cnt_l2_access != CMAX)
        |=> cnt_l2_access == $past(cnt_l2_access) + CNT_W'(1));

    p_l2_idle_r5: assert property (@(posedge clk) disable iff (rst)
        !(l2_req_valid && l2_req_ready) |=> $stable(cnt_l2_access));

    p_merge_count_r3: assert property (@(posedge clk) disable iff (rst)
        (miss_valid && miss_ready && !(l2_req_valid && l2_req_ready && l2_req_kind == 2'd0)
         && cnt_squash != CMAX)
        |=> cnt_squash == $past(cnt_squash) + CNT_W'(1));

    p_store_yield_r8: assert property (@(posedge clk) disable iff (rst)
        (st_valid && !st_ready && l2_req_ready) |-> (l2_req_valid && l2_req_kind == 2'd0));

    p_pf_yield_r8: assert property (@(posedge clk) disable iff (rst)
        (pf_valid && !pf_ready && l2_req_ready) |-> (l2_req_valid && l2_req_kind != 2'd2));

    p_done_mask_r10: assert property (@(posedge clk) disable iff (rst)
        done_valid |-> done_mask != '0);

    p_hold_max_r11: assert property (@(posedge clk) disable iff (rst)
        cnt_l1_miss == CMAX |=> cnt_l1_miss == CMAX);

    p_squash_bound_r3: assert property (@(posedge clk) disable iff (rst)
        cnt_squash <= cnt_l1_miss);
endmodule

bind mm_fill_tracker mm_fill_tracker_chk #(
    .ADDR_W(ADDR_W), .NTAGS(NTAGS), .CNT_W(CNT_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .miss_valid   (miss_valid),
    .miss_ready   (miss_ready),
    .st_valid     (st_valid),
    .st_ready     (st_ready),
    .pf_valid     (pf_valid),
    .pf_ready     (pf_ready),
    .l2_req_valid (l2_req_valid),
    .l2_req_ready (l2_req_ready),
    .l2_req_kind  (l2_req_kind),
    .done_valid   (done_valid),
    .done_mask    (done_mask),
    .cnt_l1_miss  (cnt_l1_miss),
    .cnt_squash   (cnt_squash),
    .cnt_l2_access(cnt_l2_access)
);

// File: tb/test_mm_fill_tracker.sv
module test_mm_fill_tracker;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic        miss_valid = 0, st_valid = 0, pf_valid = 0, l2_req_ready = 0, fill_valid = 0;
    logic [31:0] miss_addr = 0, st_addr = 0, pf_addr = 0;
    logic [2:0]  miss_tag = 0;
    logic [25:0] fill_line = 0;

    logic        miss_ready, st_ready, pf_ready, l2_req_valid, done_valid;
    logic [31:0] l2_req_addr;
    logic [1:0]  l2_req_kind;
    logic [7:0]  done_mask;
    logic [31:0] cnt_l1_miss, cnt_squash, cnt_l2_access;

    logic        s_mr, s_sr, s_pr, s_lv, s_dv;
    logic [31:0] s_la;
    logic [1:0]  s_lk;
    logic [7:0]  s_dm;
    logic [2:0]  s_l1, s_sq, s_l2;

    mm_fill_tracker i_mm_fill_tracker (
        .clk(clk), .rst(rst),
        .miss_valid(miss_valid), .miss_ready(miss_ready), .miss_addr(miss_addr), .miss_tag(miss_tag),
        .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr),
        .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_addr(pf_addr),
        .l2_req_valid(l2_req_valid), .l2_req_ready(l2_req_ready),
        .l2_req_addr(l2_req_addr), .l2_req_kind(l2_req_kind),
        .fill_valid(fill_valid), .fill_line(fill_line),
        .done_valid(done_valid), .done_mask(done_mask),
        .cnt_l1_miss(cnt_l1_miss), .cnt_squash(cnt_squash), .cnt_l2_access(cnt_l2_access)
    );

    // Same stimulus, 3-bit counters, to reach saturation quickly.
    mm_fill_tracker #(.CNT_W(3)) i_small (
        .clk(clk), .rst(rst),
        .miss_valid(miss_valid), .miss_ready(s_mr), .miss_addr(miss_addr), .miss_tag(miss_tag),
        .st_valid(st_valid), .st_ready(s_sr), .st_addr(st_addr),
        .pf_valid(pf_valid), .pf_ready(s_pr), .pf_addr(pf_addr),
        .l2_req_valid(s_lv), .l2_req_ready(l2_req_ready),
        .l2_req_addr(s_la), .l2_req_kind(s_lk),
        .fill_valid(fill_valid), .fill_line(fill_line),
        .done_valid(s_dv), .done_mask(s_dm),
        .cnt_l1_miss(s_l1), .cnt_squash(s_sq), .cnt_l2_access(s_l2)
    );

    typedef struct packed {
        logic        mv;  logic [31:0] ma; logic [2:0] mt;
        logic        sv;  logic [31:0] sa;
        logic        pv;  logic [31:0] pa;
        logic        rdy;
        logic        fv;  logic [25:0] fl;
        logic        emr; logic esr; logic epr; logic elv;
        logic [1:0]  ek;  logic [31:0] eaddr;
        logic        edv; logic [7:0] emask;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VEC [NV] = '{
        // R2: first miss to line 0x40
        '{1'b1, 32'h1000, 3'd0, 1'b0, 32'h0, 1'b0, 32'h0, 1'b1, 1'b0, 26'h0,
          1'b1, 1'b0, 1'b0, 1'b1, 2'd0, 32'h1000, 1'b0, 8'h00},
        // R3: same line (bits 31..6 equal), merged
        '{1'b1, 32'h103F, 3'd3, 1'b0, 32'h0, 1'b0, 32'h0, 1'b1, 1'b0, 26'h0,
          1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 32'h0, 1'b0, 8'h00},
        // R1: next line is distinct
        '{1'b1, 32'h1040, 3'd1, 1'b0, 32'h0, 1'b0, 32'h0, 1'b1, 1'b0, 26'h0,
          1'b1, 1'b0, 1'b0, 1'b1, 2'd0, 32'h1040, 1'b0, 8'h00},
        // R8: miss beats store and prefetch
        '{1'b1, 32'h2000, 3'd2, 1'b1, 32'h9000, 1'b1, 32'hA000, 1'b1, 1'b0, 26'h0,
          1'b1, 1'b0, 1'b0, 1'b1, 2'd0, 32'h2000, 1'b0, 8'h00},
        // R6: store beats prefetch
        '{1'b0, 32'h0, 3'd0, 1'b1, 32'h9004, 1'b1, 32'hA000, 1'b1, 1'b0, 26'h0,
          1'b0, 1'b1, 1'b0, 1'b1, 2'd1, 32'h9004, 1'b0, 8'h00},
        // R7: prefetch issued
        '{1'b0, 32'h0, 3'd0, 1'b0, 32'h0, 1'b1, 32'hA000, 1'b1, 1'b0, 26'h0,
          1'b0, 1'b0, 1'b1, 1'b1, 2'd2, 32'hA000, 1'b0, 8'h00},
        // R7: prefetch to live line dropped
        '{1'b0, 32'h0, 3'd0, 1'b0, 32'h0, 1'b1, 32'h1010, 1'b1, 1'b0, 26'h0,
          1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 32'h0, 1'b0, 8'h00},
        // R2: L2 not ready, miss held
        '{1'b1, 32'h3000, 3'd4, 1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 1'b0, 26'h0,
          1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 32'h3000, 1'b0, 8'h00},
        // R2: same miss taken, table now full
        '{1'b1, 32'h3000, 3'd4, 1'b0, 32'h0, 1'b0, 32'h0, 1'b1, 1'b0, 26'h0,
          1'b1, 1'b0, 1'b0, 1'b1, 2'd0, 32'h3000, 1'b0, 8'h00},
        // R9: full, new line stalls
        '{1'b1, 32'h4000, 3'd5, 1'b0, 32'h0, 1'b0, 32'h0, 1'b1, 1'b0, 26'h0,
          1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 32'h0, 1'b0, 8'h00},
        // R9: full, merge still accepted
        '{1'b1, 32'h2008, 3'd6, 1'b0, 32'h0, 1'b0, 32'h0, 1'b1, 1'b0, 26'h0,
          1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 32'h0, 1'b0, 8'h00},
        // R10: fill line 0x40, tags 0 and 3
        '{1'b0, 32'h0, 3'd0, 1'b0, 32'h0, 1'b0, 32'h0, 1'b1, 1'b1, 26'h40,
          1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 32'h0, 1'b1, 8'h09},
        // R10: fill for a line that is not live
        '{1'b0, 32'h0, 3'd0, 1'b0, 32'h0, 1'b0, 32'h0, 1'b1, 1'b1, 26'h1234,
          1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 32'h0, 1'b0, 8'h00},
        // R10: freed line reallocated, fill of 0x41 alongside
        '{1'b1, 32'h1000, 3'd7, 1'b0, 32'h0, 1'b0, 32'h0, 1'b1, 1'b1, 26'h41,
          1'b1, 1'b0, 1'b0, 1'b1, 2'd0, 32'h1000, 1'b1, 8'h02},
        // R10: miss in the cycle of its own line's fill is new
        '{1'b1, 32'h2010, 3'd0, 1'b0, 32'h0, 1'b0, 32'h0, 1'b1, 1'b1, 26'h80,
          1'b1, 1'b0, 1'b0, 1'b1, 2'd0, 32'h2010, 1'b1, 8'h44},
        // R6: store offered, L2 not ready
        '{1'b0, 32'h0, 3'd0, 1'b1, 32'h1000, 1'b0, 32'h0, 1'b0, 1'b0, 26'h0,
          1'b0, 1'b0, 1'b0, 1'b1, 2'd1, 32'h1000, 1'b0, 8'h00}
    };

    function automatic string vreq(input int k);
        case (k)
            0, 7, 8:            return "R2";
            1:                  return "R3";
            2:                  return "R1";
            3:                  return "R8";
            4, 15:              return "R6";
            5, 6:               return "R7";
            9, 10:              return "R9";
            default:            return "R10";
        endcase
    endfunction

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic drive_idle();
        miss_valid = 0; miss_addr = 0; miss_tag = 0;
        st_valid = 0; st_addr = 0; pf_valid = 0; pf_addr = 0;
        l2_req_ready = 0; fill_valid = 0; fill_line = 0;
    endtask

    int e_l1 = 0, e_sq = 0, e_l2 = 0;

    initial begin
        #2000000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        drive_idle();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #2;
        // R11: reset state
        check(cnt_l1_miss == 0, "R11", "l1 after reset", 64'(cnt_l1_miss), 0);
        check(cnt_squash == 0, "R11", "squash after reset", 64'(cnt_squash), 0);
        check(cnt_l2_access == 0, "R11", "l2 after reset", 64'(cnt_l2_access), 0);
        check(done_valid == 0, "R11", "done after reset", 64'(done_valid), 0);

        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            miss_valid = VEC[k].mv; miss_addr = VEC[k].ma; miss_tag = VEC[k].mt;
            st_valid = VEC[k].sv; st_addr = VEC[k].sa;
            pf_valid = VEC[k].pv; pf_addr = VEC[k].pa;
            l2_req_ready = VEC[k].rdy;
            fill_valid = VEC[k].fv; fill_line = VEC[k].fl;
            #2;
            if (VEC[k].mv) check(miss_ready == VEC[k].emr, vreq(k), "miss_ready", 64'(miss_ready), 64'(VEC[k].emr));
            if (VEC[k].sv) check(st_ready == VEC[k].esr, vreq(k), "st_ready", 64'(st_ready), 64'(VEC[k].esr));
            if (VEC[k].pv) check(pf_ready == VEC[k].epr, vreq(k), "pf_ready", 64'(pf_ready), 64'(VEC[k].epr));
            check(l2_req_valid == VEC[k].elv, vreq(k), "l2_req_valid", 64'(l2_req_valid), 64'(VEC[k].elv));
            if (VEC[k].elv) begin
                check(l2_req_kind == VEC[k].ek, vreq(k), "l2_req_kind", 64'(l2_req_kind), 64'(VEC[k].ek));
                check(l2_req_addr == VEC[k].eaddr, vreq(k), "l2_req_addr", 64'(l2_req_addr), 64'(VEC[k].eaddr));
            end
            check(done_valid == VEC[k].edv, vreq(k), "done_valid", 64'(done_valid), 64'(VEC[k].edv));
            if (VEC[k].edv)
                check(done_mask == VEC[k].emask, vreq(k), "done_mask", 64'(done_mask), 64'(VEC[k].emask));
            if (VEC[k].mv && VEC[k].emr) e_l1++;
            if (VEC[k].mv && VEC[k].emr && !(VEC[k].elv && VEC[k].rdy && VEC[k].ek == 2'd0)) e_sq++;
            if (VEC[k].elv && VEC[k].rdy) e_l2++;
            @(posedge clk);
            #1;
            check(cnt_l1_miss == 32'(e_l1), "R4", "cnt_l1_miss", 64'(cnt_l1_miss), 64'(e_l1));
            check(cnt_squash == 32'(e_sq), "R3", "cnt_squash", 64'(cnt_squash), 64'(e_sq));
            check(cnt_l2_access == 32'(e_l2), "R5", "cnt_l2_access", 64'(cnt_l2_access), 64'(e_l2));
        end

        // R11: 3-bit counters stop at 7
        check(s_l1 == 3'd7, "R11", "small l1 saturated", 64'(s_l1), 7);
        check(s_l2 == 3'd7, "R11", "small l2 saturated", 64'(s_l2), 7);
        check(s_sq == 3'd2, "R11", "small squash", 64'(s_sq), 2);

        // R11: reset clears counters and entries
        @(negedge clk);
        drive_idle();
        rst = 1;
        @(negedge clk);
        rst = 0;
        #2;
        check(cnt_l1_miss == 0, "R11", "l1 after re-reset", 64'(cnt_l1_miss), 0);
        check(cnt_l2_access == 0, "R11", "l2 after re-reset", 64'(cnt_l2_access), 0);
        @(negedge clk);
        fill_valid = 1; fill_line = 26'hC0;
        #2;
        check(done_valid == 0, "R11", "fill after reset finds no entry", 64'(done_valid), 0);
        @(negedge clk);
        fill_valid = 0;
        miss_valid = 1; miss_addr = 32'h3000; miss_tag = 3'd1; l2_req_ready = 1;
        #2;
        check(l2_req_valid == 1, "R2", "fresh miss after reset issues", 64'(l2_req_valid), 1);
        @(negedge clk);
        drive_idle();
        #2;

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule